// File: doc/BRIEF.md
# SDRAM Cycle Arbiter and Command Generator

This block is the core engine of a single-data-rate SDRAM controller. It chooses, one cycle at a time, between three kinds of work: refresh cycles asked for by an internal interval timer, command cycles asked for by a power-up sequencer, and data cycles asked for by a processor through a synchronous select and write strobe. Each cycle runs a 4-bit step counter. The pair of cycle kind and step is the only state that the pin decoder reads to drive the memory control pins and the processor acknowledge.

After reset the sequencer waits for an enable. It then issues a precharge of all banks, two auto refreshes and a mode-register load, and raises a sticky setup flag. From then on the refresh timer runs, and processor cycles are served. A processor cycle opens a row, issues a read or write with auto-precharge two clocks later and acknowledges each data beat. A processor terminate input closes the burst early with a burst-terminate command. Two memory regions of 16 MB each, 4M words of 32 bits, sit behind separate chip selects.

Top module: `sdram_cycle_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `setup_done` is 0, both chip selects are high, `cpu_ack_n` is 1 and `sd_cke` is 1.
- R2: No memory command is issued while `init_enable` is low. A processor select held low before `setup_done` rises starts no data cycle.
- R3: At most 6 clocks after `init_enable` rises, the block issues precharge (A10 high), refresh, refresh and load-mode, in that order, on both chip selects. Each command follows the previous one by CMD_CYCLES+1 clocks. Load-mode drives bank 0 and the mode word {2'b00, 1'b0, 2'b00, CL[2:0], 1'b0, log2(BURST_LEN)[2:0]}. `setup_done` rises CMD_CYCLES+1 clocks after the load-mode command and never falls.
- R4: Commands on {ras_n, cas_n, we_n} with a chip select low are: activate 011, read 101, write 100, burst terminate 110, precharge 010, refresh 001, load-mode 000, NOP 111. Both chip selects are low together only for a command with ras_n low.
- R5: A data cycle starts with activate on chip select 0 when word-address bit 24 is 0 and on chip select 1 when it is 1. The bank is address bits 23:22 and the row is bits 21:10.
- R6: Exactly two clocks after activate, the block issues read (`cpu_wr_n` high at acceptance) or write. It drives the same bank, address bits 7:0 from address bits 9:2, A10 high for auto-precharge and bits 11, 9 and 8 low. The clock right after activate carries no read, write or activate.
- R7: `cpu_ack_n` is low for BURST_LEN consecutive clocks. For a write this starts with the write command. For a read it starts CAS_LAT clocks after the read command. It is high at all other times.
- R8: From the read/write command to the end of the data cycle, `sd_dqm` equals the inverted `cpu_byte_en`. At all other times it is all ones.
- R9: `cpu_term_n` low in a data-cycle step from one clock after the read/write command through the last acknowledge step makes that clock a burst terminate with `cpu_ack_n` high. The next clock is a NOP on the same chip select, and the clock after that is idle with both chip selects high.
- R10: After setup, refresh commands (both chip selects) recur. Between successive ones there are at least REFRESH_INTERVAL+2 and at most REFRESH_INTERVAL+DATA_LAST+4 clocks, where DATA_LAST = CAS_LAT+BURST_LEN+3.
- R11: A pending refresh wins over a pending processor request. The activate then follows the refresh command by REF_CYCLES+1 clocks.
- R12: `sd_cke` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_enable | input | 1 | Allows initialization, synchronized inside |
| cpu_sel_n | input | 1 | Processor memory select, active low, synchronous |
| cpu_wr_n | input | 1 | Processor write strobe, low for write |
| cpu_term_n | input | 1 | Processor burst terminate, active low |
| cpu_addr | input | 23 | Processor word address, bits 24:2 |
| cpu_byte_en | input | 4 | Byte lane enables, high = lane active |
| sd_cke | output | 1 | Memory clock enable |
| sd_ba | output | 2 | Memory bank address |
| sd_cs0_n | output | 1 | Chip select, lower region |
| sd_cs1_n | output | 1 | Chip select, upper region |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable strobe |
| sd_addr | output | 12 | Memory address |
| sd_dqm | output | 4 | Data mask per lane |
| cpu_ack_n | output | 1 | Data beat acknowledge, active low |
| setup_done | output | 1 | Initialization complete |

## Verification
The hardest case to reach from the ports is a refresh request that arrives while a processor request is already waiting. The arbitration order and the activate delay that follows can only be seen in that window. The stimulus shortens the refresh interval and issues processor cycles back to back without a gap, so the timer expires while a request is queued, many times over. The bench counts these collisions and checks the refresh-to-activate spacing each time. A processor select held low throughout initialization covers the case where a request must be ignored.

// File: rtl/sdce_pkg.sv
package sdce_pkg;

    // Word address layout (bit positions of the byte address)
    localparam int AW         = 25;
    localparam int REGION_BIT = 24;
    localparam int BANK_HI    = 23;
    localparam int BANK_LO    = 22;
    localparam int ROW_HI     = 21;
    localparam int ROW_LO     = 10;
    localparam int COL_HI     = 9;
    localparam int COL_LO     = 2;
    localparam int SD_AW      = ROW_HI - ROW_LO + 1;
    localparam int COL_W      = COL_HI - COL_LO + 1;
    localparam int BA_W       = BANK_HI - BANK_LO + 1;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'b00,
        CYC_CMD  = 2'b01,
        CYC_DATA = 2'b10,
        CYC_REF  = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        IC_NOP       = 2'b00,
        IC_PRECHARGE = 2'b01,
        IC_REFRESH   = 2'b10,
        IC_LOADMODE  = 2'b11
    } initcmd_e;

    // {ras_n, cas_n, we_n}
    typedef logic [2:0] strobe_t;
    localparam strobe_t SB_NOP = 3'b111;
    localparam strobe_t SB_ACT = 3'b011;
    localparam strobe_t SB_RD  = 3'b101;
    localparam strobe_t SB_WR  = 3'b100;
    localparam strobe_t SB_BST = 3'b110;
    localparam strobe_t SB_PRE = 3'b010;
    localparam strobe_t SB_REF = 3'b001;
    localparam strobe_t SB_LMR = 3'b000;

    function automatic logic [2:0] burst_code(input int bl);
        case (bl)
            1:       burst_code = 3'd0;
            2:       burst_code = 3'd1;
            4:       burst_code = 3'd2;
            default: burst_code = 3'd3;
        endcase
    endfunction

    function automatic logic [SD_AW-1:0] mode_word(input int cl, input int bl);
        logic [SD_AW-1:0] w;
        w      = '0;
        w[2:0] = burst_code(bl);
        w[3]   = 1'b0;          // sequential ordering
        w[6:4] = 3'(cl);
        mode_word = w;
    endfunction

endpackage

// File: rtl/sdce_init_seq.sv
module sdce_init_seq
    import sdce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  cyc_e       cyc,
    input  logic [3:0] step,
    output logic       cmd_req,
    output initcmd_e   cmd_code,
    output logic       setup_done
);

    typedef enum logic [2:0] {
        PH_WAIT, PH_PRE, PH_REF1, PH_REF2, PH_LMR, PH_DONE
    } phase_e;

    typedef struct packed {
        logic [1:0] sync;
        phase_e     phase;
        logic       setup;
    } init_t;

    init_t s_q, s_d;
    logic  taken;

    assign taken = (cyc == CYC_CMD) && (step == 4'd0);

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], enable};
        case (s_q.phase)
            PH_WAIT: if (s_q.sync[1]) s_d.phase = PH_PRE;
            PH_PRE:  if (taken) s_d.phase = PH_REF1;
            PH_REF1: if (taken) s_d.phase = PH_REF2;
            PH_REF2: if (taken) s_d.phase = PH_LMR;
            PH_LMR:  if (taken) s_d.phase = PH_DONE;
            default: s_d.phase = PH_DONE;
        endcase
        if (s_q.phase == PH_DONE && cyc == CYC_IDLE)
            s_d.setup = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sync: 2'b00, phase: PH_WAIT, setup: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        cmd_req  = 1'b1;
        cmd_code = IC_NOP;
        case (s_q.phase)
            PH_PRE:  cmd_code = IC_PRECHARGE;
            PH_REF1: cmd_code = IC_REFRESH;
            PH_REF2: cmd_code = IC_REFRESH;
            PH_LMR:  cmd_code = IC_LOADMODE;
            default: cmd_req  = 1'b0;
        endcase
    end

    assign setup_done = s_q.setup;

endmodule

// File: rtl/sdce_refresh_timer.sv
module sdce_refresh_timer
    import sdce_pkg::*;
#(
    parameter int INTERVAL = 3900,
    parameter int CNT_W    = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_done,
    input  cyc_e       cyc,
    input  logic [3:0] step,
    output logic       ref_req
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } tmr_t;

    tmr_t t_q, t_d;
    logic started;

    assign started = (cyc == CYC_REF) && (step == 4'd0);

    always_comb begin
        t_d = t_q;
        if (!setup_done || started) begin
            t_d.cnt = '0;
            t_d.req = 1'b0;
        end else if (!t_q.req) begin
            if (t_q.cnt == LIMIT) t_d.req = 1'b1;
            else                  t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ref_req = t_q.req;

endmodule

// File: rtl/sdce_cycle_seq.sv
module sdce_cycle_seq
    import sdce_pkg::*;
#(
    parameter int CAS_LAT    = 2,
    parameter int BURST_LEN  = 4,
    parameter int CMD_CYCLES = 8,
    parameter int REF_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_req,
    input  logic                cmd_req,
    input  logic                setup_done,
    input  logic                sel_n,
    input  logic                wr_n,
    input  logic                term_n,
    input  logic [AW-1:COL_LO]  addr,
    output cyc_e                cyc,
    output logic [3:0]          step,
    output logic [AW-1:COL_LO]  addr_q,
    output logic                wr_q,
    output logic                term_hit
);

    localparam int DATA_LAST_I = CAS_LAT + BURST_LEN + 3;
    localparam logic [3:0] DATA_LAST = 4'(DATA_LAST_I);
    localparam logic [3:0] CMD_LAST  = 4'(CMD_CYCLES - 1);
    localparam logic [3:0] REF_LAST  = 4'(REF_CYCLES - 1);
    localparam logic [3:0] WR_ACK_END = 4'(2 + BURST_LEN - 1);
    localparam logic [3:0] RD_ACK_END = 4'(1 + CAS_LAT + BURST_LEN);

    typedef struct packed {
        cyc_e                cyc;
        logic [3:0]          step;
        logic [AW-1:COL_LO]  addr;
        logic                wr;
    } seq_t;

    seq_t q, d;
    logic [3:0] ack_end;

    assign ack_end  = q.wr ? WR_ACK_END : RD_ACK_END;
    assign term_hit = (q.cyc == CYC_DATA) && (q.step >= 4'd3) &&
                      (q.step <= ack_end) && !term_n;

    always_comb begin
        d = q;
        case (q.cyc)
            CYC_IDLE: begin
                d.step = '0;
                if (ref_req)                    d.cyc = CYC_REF;
                else if (cmd_req)               d.cyc = CYC_CMD;
                else if (setup_done && !sel_n) begin
                    d.cyc  = CYC_DATA;
                    d.addr = addr;
                    d.wr   = !wr_n;
                end
            end
            CYC_CMD: begin
                if (q.step == CMD_LAST) begin
                    d.cyc  = CYC_IDLE;
                    d.step = '0;
                end else d.step = q.step + 1'b1;
            end
            CYC_REF: begin
                if (q.step == REF_LAST) begin
                    d.cyc  = CYC_IDLE;
                    d.step = '0;
                end else d.step = q.step + 1'b1;
            end
            default: begin
                if (term_hit)                d.step = DATA_LAST;
                else if (q.step == DATA_LAST) begin
                    d.cyc  = CYC_IDLE;
                    d.step = '0;
                end else d.step = q.step + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cyc: CYC_IDLE, step: '0, addr: '0, wr: 1'b0};
        else        q <= d;
    end

    assign cyc    = q.cyc;
    assign step   = q.step;
    assign addr_q = q.addr;
    assign wr_q   = q.wr;

endmodule

// File: rtl/sdce_pin_decode.sv
module sdce_pin_decode
    import sdce_pkg::*;
#(
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4,
    parameter int LANES     = 4
) (
    input  cyc_e                cyc,
    input  logic [3:0]          step,
    input  logic [AW-1:COL_LO]  addr_q,
    input  logic                wr_q,
    input  logic                term_hit,
    input  initcmd_e            cmd_code,
    input  logic [LANES-1:0]    byte_en,
    output logic [BA_W-1:0]     ba,
    output logic                cs0_n,
    output logic                cs1_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [SD_AW-1:0]    a,
    output logic [LANES-1:0]    dqm,
    output logic                ack_n
);

    localparam logic [SD_AW-1:0] MODE = mode_word(CAS_LAT, BURST_LEN);
    localparam logic [3:0] WR_ACK_BEG = 4'd2;
    localparam logic [3:0] RD_ACK_BEG = 4'(2 + CAS_LAT);
    localparam logic [3:0] WR_ACK_END = 4'(2 + BURST_LEN - 1);
    localparam logic [3:0] RD_ACK_END = 4'(1 + CAS_LAT + BURST_LEN);

    strobe_t    sb;
    logic [3:0] beg_s, end_s;

    assign beg_s = wr_q ? WR_ACK_BEG : RD_ACK_BEG;
    assign end_s = wr_q ? WR_ACK_END : RD_ACK_END;
    assign {ras_n, cas_n, we_n} = sb;

    always_comb begin
        cs0_n = 1'b1;
        cs1_n = 1'b1;
        sb    = SB_NOP;
        ba    = '0;
        a     = '0;
        dqm   = '1;
        ack_n = 1'b1;
        case (cyc)
            CYC_CMD: begin
                if (step == 4'd0) begin
                    cs0_n = 1'b0;
                    cs1_n = 1'b0;
                    case (cmd_code)
                        IC_PRECHARGE: begin sb = SB_PRE; a[10] = 1'b1; end
                        IC_REFRESH:   sb = SB_REF;
                        IC_LOADMODE:  begin sb = SB_LMR; a = MODE; end
                        default:      sb = SB_NOP;
                    endcase
                end
            end
            CYC_REF: begin
                if (step == 4'd0) begin
                    cs0_n = 1'b0;
                    cs1_n = 1'b0;
                    sb    = SB_REF;
                end
            end
            CYC_DATA: begin
                cs0_n = addr_q[REGION_BIT];
                cs1_n = !addr_q[REGION_BIT];
                ba    = addr_q[BANK_HI:BANK_LO];
                if (step == 4'd0) begin
                    sb = SB_ACT;
                    a  = addr_q[ROW_HI:ROW_LO];
                end else if (step == 4'd2) begin
                    sb          = wr_q ? SB_WR : SB_RD;
                    a[COL_W-1:0] = addr_q[COL_HI:COL_LO];
                    a[10]       = 1'b1;
                end else if (term_hit) begin
                    sb = SB_BST;
                end
                if (step >= 4'd2) dqm = ~byte_en;
                if (!term_hit && step >= beg_s && step <= end_s) ack_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_cycle_engine.sv
module sdram_cycle_engine
    import sdce_pkg::*;
#(
    parameter int CAS_LAT          = 2,
    parameter int BURST_LEN        = 4,
    parameter int LANES            = 4,
    parameter int REFRESH_INTERVAL = 3900,
    parameter int REFRESH_CNT_W    = 12,
    parameter int CMD_CYCLES       = 8,
    parameter int REF_CYCLES       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_enable,
    input  logic                cpu_sel_n,
    input  logic                cpu_wr_n,
    input  logic                cpu_term_n,
    input  logic [AW-1:COL_LO]  cpu_addr,
    input  logic [LANES-1:0]    cpu_byte_en,
    output logic                sd_cke,
    output logic [BA_W-1:0]     sd_ba,
    output logic                sd_cs0_n,
    output logic                sd_cs1_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [SD_AW-1:0]    sd_addr,
    output logic [LANES-1:0]    sd_dqm,
    output logic                cpu_ack_n,
    output logic                setup_done
);

    cyc_e               cyc;
    logic [3:0]         step;
    logic [AW-1:COL_LO] addr_q;
    logic               wr_q, term_hit, cmd_req, ref_req;
    initcmd_e           cmd_code;

    assign sd_cke = 1'b1;

    sdce_init_seq u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (init_enable),
        .cyc        (cyc),
        .step       (step),
        .cmd_req    (cmd_req),
        .cmd_code   (cmd_code),
        .setup_done (setup_done)
    );

    sdce_refresh_timer #(
        .INTERVAL (REFRESH_INTERVAL),
        .CNT_W    (REFRESH_CNT_W)
    ) u_rtmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_done (setup_done),
        .cyc        (cyc),
        .step       (step),
        .ref_req    (ref_req)
    );

    sdce_cycle_seq #(
        .CAS_LAT    (CAS_LAT),
        .BURST_LEN  (BURST_LEN),
        .CMD_CYCLES (CMD_CYCLES),
        .REF_CYCLES (REF_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_req    (ref_req),
        .cmd_req    (cmd_req),
        .setup_done (setup_done),
        .sel_n      (cpu_sel_n),
        .wr_n       (cpu_wr_n),
        .term_n     (cpu_term_n),
        .addr       (cpu_addr),
        .cyc        (cyc),
        .step       (step),
        .addr_q     (addr_q),
        .wr_q       (wr_q),
        .term_hit   (term_hit)
    );

    sdce_pin_decode #(
        .CAS_LAT   (CAS_LAT),
        .BURST_LEN (BURST_LEN),
        .LANES     (LANES)
    ) u_dec (
        .cyc      (cyc),
        .step     (step),
        .addr_q   (addr_q),
        .wr_q     (wr_q),
        .term_hit (term_hit),
        .cmd_code (cmd_code),
        .byte_en  (cpu_byte_en),
        .ba       (sd_ba),
        .cs0_n    (sd_cs0_n),
        .cs1_n    (sd_cs1_n),
        .ras_n    (sd_ras_n),
        .cas_n    (sd_cas_n),
        .we_n     (sd_we_n),
        .a        (sd_addr),
        .dqm      (sd_dqm),
        .ack_n    (cpu_ack_n)
    );

endmodule

// File: rtl/sdce_checker.sv
module sdce_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_cke,
    input logic             sd_cs0_n,
    input logic             sd_cs1_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [11:0]      sd_addr,
    input logic [LANES-1:0] sd_dqm,
    input logic             cpu_ack_n,
    input logic             setup_done
);

    logic any_cs, both_cs, is_act, is_rw;
    assign any_cs  = !sd_cs0_n || !sd_cs1_n;
    assign both_cs = !sd_cs0_n && !sd_cs1_n;
    assign is_act  = any_cs && !sd_ras_n && sd_cas_n && sd_we_n;
    assign is_rw   = any_cs && sd_ras_n && !sd_cas_n;

    assert_cke_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke);

    assert_dual_select_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        both_cs |-> !sd_ras_n);

    assert_autoprecharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> sd_addr[10]);

    assert_act_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> !(any_cs && (!sd_cas_n || !sd_ras_n)));

    assert_setup_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> setup_done);

    assert_ack_single_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack_n |-> (setup_done && (sd_cs0_n != sd_cs1_n)));

    assert_dqm_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs0_n && sd_cs1_n) |-> (sd_dqm == '1));

    assert_no_cmd_before_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_done && any_cs) |-> both_cs);

endmodule

bind sdram_cycle_engine sdce_checker #(.LANES(LANES)) u_sdce_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_cke     (sd_cke),
    .sd_cs0_n   (sd_cs0_n),
    .sd_cs1_n   (sd_cs1_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .sd_dqm     (sd_dqm),
    .cpu_ack_n  (cpu_ack_n),
    .setup_done (setup_done)
);

// File: tb/sdram_cycle_engine_test.sv
module sdram_cycle_engine_test;

    localparam int CL       = 2;
    localparam int BL       = 4;
    localparam int INTERVAL = 200;
    localparam int CMD_CYC  = 8;
    localparam int REF_CYC  = 8;
    localparam int DLAST    = CL + BL + 3;
    localparam logic [11:0] MODE_EXP = 12'h022;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_enable = 1'b0;
    logic        cpu_sel_n = 1'b1, cpu_wr_n = 1'b1, cpu_term_n = 1'b1;
    logic [24:2] cpu_addr = '0;
    logic [3:0]  cpu_byte_en = '0;
    logic        sd_cke, sd_cs0_n, sd_cs1_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [3:0]  sd_dqm;
    logic        cpu_ack_n, setup_done;

    int checks = 0, failures = 0, cyc_no = 0;
    int last_ref = -1, collisions = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc_no <= cyc_no + 1;

    sdram_cycle_engine #(
        .CAS_LAT(CL), .BURST_LEN(BL), .REFRESH_INTERVAL(INTERVAL),
        .CMD_CYCLES(CMD_CYC), .REF_CYCLES(REF_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .init_enable(init_enable),
        .cpu_sel_n(cpu_sel_n), .cpu_wr_n(cpu_wr_n), .cpu_term_n(cpu_term_n),
        .cpu_addr(cpu_addr), .cpu_byte_en(cpu_byte_en),
        .sd_cke(sd_cke), .sd_ba(sd_ba), .sd_cs0_n(sd_cs0_n), .sd_cs1_n(sd_cs1_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .cpu_ack_n(cpu_ack_n),
        .setup_done(setup_done)
    );

    function automatic logic [2:0] strobes();
        return {sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    function automatic int ack_beg(bit wr);
        return wr ? 2 : 2 + CL;
    endfunction

    function automatic int ack_end(bit wr);
        return ack_beg(wr) + BL - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc_no);
        end
    endtask

    // waits for the next non-NOP command; returns strobes and cycle number
    task automatic next_cmd(output logic [2:0] sb, output int t);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (!(sd_cs0_n && sd_cs1_n) && strobes() != 3'b111) begin
                sb = strobes();
                t  = cyc_no;
                return;
            end
        end
        sb = 3'b111;
        t  = cyc_no;
        check(1'b0, "timeout waiting for command", 0, 1);
    endtask

    task automatic note_refresh(input int t);
        check(!sd_cs0_n && !sd_cs1_n, "R10 refresh on both selects", {sd_cs0_n, sd_cs1_n}, 0);
        if (last_ref >= 0)
            check((t - last_ref >= INTERVAL + 2) && (t - last_ref <= INTERVAL + DLAST + 4),
                  "R10 refresh spacing", t - last_ref, INTERVAL + 2);
        last_ref = t;
    endtask

    task automatic run_txn(input logic [24:2] a, input bit wr, input logic [3:0] be,
                           input bit term, input int k);
        logic [2:0] sb;
        int t, tref, beats;
        bit saw_ref, bad_ack;
        saw_ref = 1'b0;
        tref = 0;
        cpu_sel_n   = 1'b0;
        cpu_wr_n    = !wr;
        cpu_addr    = a;
        cpu_byte_en = be;
        forever begin
            next_cmd(sb, t);
            if (sb == 3'b001) begin
                note_refresh(t);
                saw_ref = 1'b1;
                tref = t;
            end else break;
        end
        cpu_sel_n = 1'b1;
        check(sb == 3'b011, "R5 activate command", sb, 3'b011);
        check(sd_cs0_n == a[24] && sd_cs1_n == !a[24], "R5 region select",
              {sd_cs1_n, sd_cs0_n}, {!a[24], a[24]});
        check(sd_ba == a[23:22] && sd_addr == a[21:10], "R5 bank/row",
              {sd_ba, sd_addr}, {a[23:22], a[21:10]});
        check(sd_dqm == 4'hF && cpu_ack_n, "R8 mask before column", sd_dqm, 4'hF);
        if (saw_ref) begin
            collisions++;
            check(t - tref == REF_CYC + 1, "R11 activate after refresh", t - tref, REF_CYC + 1);
        end
        beats = 0;
        bad_ack = 1'b0;
        for (int off = 1; off <= DLAST; off++) begin
            @(negedge clk);
            if (term && off == k) cpu_term_n = 1'b0;
            #1;
            if (off == 1)
                check(strobes() == 3'b111, "R6 gap after activate", strobes(), 3'b111);
            if (off == 2) begin
                check(strobes() == (wr ? 3'b100 : 3'b101), "R6 read/write command",
                      strobes(), wr ? 3'b100 : 3'b101);
                check(sd_addr == {4'b0100, a[9:2]} && sd_ba == a[23:22], "R6 column address",
                      sd_addr, {4'b0100, a[9:2]});
                check(sd_dqm == ~be, "R8 mask from byte enables", sd_dqm, ~be);
            end
            if (term && off == k) begin
                check(strobes() == 3'b110 && cpu_ack_n, "R9 burst terminate",
                      {strobes(), cpu_ack_n}, 4'b1101);
                check(beats == ((k > ack_beg(wr)) ? k - ack_beg(wr) : 0), "R9 beats before stop",
                      beats, (k > ack_beg(wr)) ? k - ack_beg(wr) : 0);
                @(negedge clk); cpu_term_n = 1'b1; #1;
                check(strobes() == 3'b111 && (sd_cs0_n != sd_cs1_n) && cpu_ack_n,
                      "R9 nop after terminate", {strobes(), cpu_ack_n}, 4'b1111);
                @(negedge clk); #1;
                check(sd_cs0_n && sd_cs1_n && cpu_ack_n, "R9 idle after terminate",
                      {sd_cs0_n, sd_cs1_n}, 2'b11);
                return;
            end
            if (!cpu_ack_n) beats++;
            if ((!cpu_ack_n) != (off >= ack_beg(wr) && off <= ack_end(wr))) bad_ack = 1'b1;
        end
        check(beats == BL && !bad_ack, "R7 acknowledge window", beats, BL);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_no, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] sb;
        int t, tprev;
        void'($urandom(32'h5EED_0C1A));

        repeat (3) @(negedge clk);
        #1;
        check(!setup_done && sd_cs0_n && sd_cs1_n && cpu_ack_n && sd_cke, "R1 reset state",
              {setup_done, sd_cs0_n, sd_cs1_n, cpu_ack_n, sd_cke}, 5'b01111);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check(!setup_done && sd_cs0_n && sd_cs1_n && cpu_ack_n && sd_cke, "R1 after reset",
              {setup_done, sd_cs0_n, sd_cs1_n, cpu_ack_n, sd_cke}, 5'b01111);

        // R2: pending select while not enabled; nothing happens
        cpu_sel_n = 1'b0;
        cpu_wr_n  = 1'b0;
        cpu_addr  = 23'h12345;
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk); #1;
                if (!(sd_cs0_n && sd_cs1_n)) quiet = 1'b0;
            end
            check(quiet, "R2 idle without enable", quiet, 1);
        end

        // R3 init sequence with the select still held low (R2)
        init_enable = 1'b1;
        tprev = cyc_no;
        next_cmd(sb, t);
        check(sb == 3'b010 && sd_addr[10] && !sd_cs0_n && !sd_cs1_n, "R3 precharge first",
              {sb, sd_addr[10]}, 4'b0101);
        check(t - tprev <= 6, "R3 start latency", t - tprev, 6);
        tprev = t;
        for (int r = 0; r < 2; r++) begin
            next_cmd(sb, t);
            check(sb == 3'b001 && !sd_cs0_n && !sd_cs1_n, "R3 init refresh", sb, 3'b001);
            check(t - tprev == CMD_CYC + 1, "R3 command spacing", t - tprev, CMD_CYC + 1);
            tprev = t;
        end
        next_cmd(sb, t);
        check(sb == 3'b000 && !sd_cs0_n && !sd_cs1_n, "R3 load mode", sb, 3'b000);
        check(sd_addr == MODE_EXP && sd_ba == 2'b00, "R3 mode word", sd_addr, MODE_EXP);
        check(t - tprev == CMD_CYC + 1, "R3 command spacing", t - tprev, CMD_CYC + 1);
        cpu_sel_n = 1'b1;
        repeat (CMD_CYC) @(negedge clk);
        #1;
        check(!setup_done, "R3 setup not yet", setup_done, 0);
        @(negedge clk); #1;
        check(setup_done, "R3 setup raised", setup_done, 1);

        // directed corners
        run_txn(23'h3FFFFF, 1'b1, 4'b1010, 1'b0, 0);   // top of lower region, write
        run_txn(23'h400000, 1'b0, 4'b0101, 1'b0, 0);   // bottom of upper region, read
        run_txn(23'h2AAAAA, 1'b1, 4'hF, 1'b1, 3);      // write stopped at first legal step
        run_txn(23'h555555, 1'b0, 4'h0, 1'b1, 3);      // read stopped before any beat
        run_txn(23'h111111, 1'b0, 4'h3, 1'b1, ack_end(1'b0)); // read stopped at last beat

        // random traffic, back to back, so refresh lands on pending requests
        for (int n = 0; n < 120; n++) begin
            logic [24:2] a;
            bit wr, term;
            int k;
            a    = 23'($urandom);
            wr   = 1'($urandom);
            term = ($urandom % 4) == 0;
            k    = 3 + int'($urandom % 32'(ack_end(wr) - 2));
            run_txn(a, wr, 4'($urandom), term, k);
        end
        check(collisions > 0, "R11 refresh collided with request", collisions, 1);
        check(sd_cke && setup_done, "R12 clock enable held", {sd_cke, setup_done}, 2'b11);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule